// File: doc/BRIEF.md
# Segment-Wise Selection Query Unit

This block applies a selection query to tuples that reach it as a series of 64-bit segments, one segment per cycle. Each segment carries an attribute identifier in its upper 32 bits and a value in its lower 32 bits. The query is held as an ordered set of query entries, one for each segment position. Entry k holds an attribute id, an operator and a 32-bit constant, and it is applied to segment k of every tuple. Every segment comes out one cycle later, unchanged, with a pass flag of its own and its position within the tuple. A downstream stage can then combine the flags of a whole tuple.

Query entries are written into a staging set while tuples keep flowing. A commit request moves the staging set into the live set, but only at a tuple boundary. No tuple is ever judged by a mix of old and new entries. A position counter follows the segments of the current tuple and restarts after each segment that is marked last.

Top module: `seg_select_unit`

## Requirements
- R1: Each cycle with `segValid` high yields exactly one result on the next cycle with `resValid` high; a cycle without `segValid` yields `resValid` low on the next cycle.
- R2: `resData` equals the accepted segment bit for bit, and `resLast` equals its last-segment marker.
- R3: The segment position starts at 0, goes up by one per accepted segment, and returns to 0 after a segment marked last; `resIdx` reports it, and live entry k judges segment k.
- R4: Operator codes compare the unsigned value (bits 31:0) against the constant: 0 equal, 1 not equal, 2 less, 3 greater, 4 less-or-equal, 5 greater-or-equal. The attribute (bits 63:32) must also equal the entry's attribute id.
- R5: Code 6 passes every segment whatever its attribute and value; code 7 passes none; after reset every entry of both sets holds code 7.
- R6: For codes 0 to 5, a segment whose attribute differs from the entry's attribute id gets a cleared pass flag, even if its value meets the condition.
- R7: A write to the staging set does not change any result until a commit takes effect.
- R8: A commit request, in the same cycle or pending, takes effect in the first cycle that is a tuple boundary. That is either a cycle at position 0 with no segment offered, or a cycle that accepts a segment marked last. The new entries judge the segments after that cycle, and a staging write made in that same cycle is part of the copy.
- R9: Segments at positions MAX_SEGS and beyond always fail, and `resIdx` stays at MAX_SEGS for them until the tuple ends.
- R10: During reset `resValid`, `resPass` and `resLast` are low, the position is 0 and no commit is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| segValid | input | 1 | A segment is offered this cycle |
| segData | input | 64 | Segment: attribute in 63:32, value in 31:0 |
| segLast | input | 1 | Offered segment ends its tuple |
| qWrEn | input | 1 | Write one staging entry |
| qWrIdx | input | QIDX_W | Position of the staging entry to write |
| qWrAttr | input | 32 | Attribute id for the entry |
| qWrOp | input | 3 | Operator code for the entry |
| qWrConst | input | 32 | Comparison constant for the entry |
| qCommit | input | 1 | Request to move staging entries into the live set |
| resValid | output | 1 | A result segment is present |
| resData | output | 64 | Result segment, copy of the input |
| resLast | output | 1 | Result ends its tuple |
| resPass | output | 1 | Result segment met its query entry |
| resIdx | output | CNT_W | Position of the result within its tuple |

## Verification
The properties assume that `segValid` may toggle freely and that `segLast` is looked at only while `segValid` is high. They also assume that `qWrIdx` names an existing entry whenever `qWrEn` is set. The position properties compare consecutive results only, so they stay sound whatever the gaps between segments. The stimulus keeps write positions below MAX_SEGS and mixes idle cycles, back-to-back segments, mid-tuple commits and over-long tuples. Pass flags are checked against a behavioural model of the staging and live sets.

// File: rtl/seg_select_pkg.sv
`timescale 1ns/1ps
package seg_select_pkg;

  localparam int ATTR_W = 32;
  localparam int VAL_W  = 32;
  localparam int SEG_W  = ATTR_W + VAL_W;

  typedef enum logic [2:0] {
    OP_EQ    = 3'd0,
    OP_NE    = 3'd1,
    OP_LT    = 3'd2,
    OP_GT    = 3'd3,
    OP_LE    = 3'd4,
    OP_GE    = 3'd5,
    OP_ANY   = 3'd6,
    OP_NEVER = 3'd7
  } selOp_e;

  typedef struct packed {
    logic [ATTR_W-1:0] attr;
    selOp_e            op;
    logic [VAL_W-1:0]  konst;
  } qEntry_t;

  localparam qEntry_t Q_IDLE = '{attr: '0, op: OP_NEVER, konst: '0};

  // strobes from control to datapath
  typedef struct packed {
    logic evalEn;
    logic lastSeg;
    logic overRun;
    logic swapBanks;
  } ctrlStrobe_t;

endpackage

// File: rtl/seg_select_cmp.sv
`timescale 1ns/1ps
module seg_select_cmp
  import seg_select_pkg::*;
(
  input  qEntry_t          entry,
  input  logic [SEG_W-1:0] seg,
  output logic             hit
);

  logic [ATTR_W-1:0] segAttr;
  logic [VAL_W-1:0]  segVal;
  logic              attrOk;

  assign segAttr = seg[SEG_W-1:VAL_W];
  assign segVal  = seg[VAL_W-1:0];
  assign attrOk  = (segAttr == entry.attr);

  always_comb begin
    unique case (entry.op)
      OP_EQ:    hit = attrOk && (segVal == entry.konst);
      OP_NE:    hit = attrOk && (segVal != entry.konst);
      OP_LT:    hit = attrOk && (segVal <  entry.konst);
      OP_GT:    hit = attrOk && (segVal >  entry.konst);
      OP_LE:    hit = attrOk && (segVal <= entry.konst);
      OP_GE:    hit = attrOk && (segVal >= entry.konst);
      OP_ANY:   hit = 1'b1;
      OP_NEVER: hit = 1'b0;
      default:  hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/seg_select_ctrl.sv
`timescale 1ns/1ps
module seg_select_ctrl
  import seg_select_pkg::*;
#(
  parameter int MAX_SEGS = 4,
  localparam int CNT_W = $clog2(MAX_SEGS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             segValid,
  input  logic             segLast,
  input  logic             qCommit,
  output ctrlStrobe_t      strb,
  output logic [CNT_W-1:0] segIdx
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_SEGS);

  logic [CNT_W-1:0] segCnt;
  logic             pending;
  logic             wantSwap;
  logic             atBoundary;

  assign wantSwap   = pending || qCommit;
  assign atBoundary = (segCnt == '0 && !segValid) || (segValid && segLast);

  always_comb begin
    strb.evalEn    = segValid;
    strb.lastSeg   = segLast;
    strb.overRun   = (segCnt == CNT_SAT);
    strb.swapBanks = wantSwap && atBoundary;
  end

  assign segIdx = segCnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      segCnt  <= '0;
      pending <= 1'b0;
    end else begin
      pending <= wantSwap && !atBoundary;
      if (segValid) begin
        if (segLast)
          segCnt <= '0;
        else if (segCnt != CNT_SAT)
          segCnt <= segCnt + CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/seg_select_dp.sv
`timescale 1ns/1ps
module seg_select_dp
  import seg_select_pkg::*;
#(
  parameter int MAX_SEGS = 4,
  localparam int CNT_W  = $clog2(MAX_SEGS + 1),
  localparam int QIDX_W = (MAX_SEGS > 1) ? $clog2(MAX_SEGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [CNT_W-1:0]  segIdx,
  input  logic [SEG_W-1:0]  segData,
  input  logic              qWrEn,
  input  logic [QIDX_W-1:0] qWrIdx,
  input  logic [ATTR_W-1:0] qWrAttr,
  input  logic [2:0]        qWrOp,
  input  logic [VAL_W-1:0]  qWrConst,
  output logic              resValid,
  output logic [SEG_W-1:0]  resData,
  output logic              resLast,
  output logic              resPass,
  output logic [CNT_W-1:0]  resIdx
);

  qEntry_t stageQ [MAX_SEGS];
  qEntry_t liveQ  [MAX_SEGS];
  qEntry_t newEntry;
  qEntry_t curEntry;
  logic    segHit;

  always_comb begin
    newEntry.attr  = qWrAttr;
    newEntry.op    = selOp_e'(qWrOp);
    newEntry.konst = qWrConst;
  end

  for (genvar g = 0; g < MAX_SEGS; g++) begin : g_entry
    qEntry_t stageNext;
    assign stageNext = (qWrEn && qWrIdx == QIDX_W'(g)) ? newEntry : stageQ[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stageQ[g] <= Q_IDLE;
        liveQ[g]  <= Q_IDLE;
      end else begin
        stageQ[g] <= stageNext;
        if (strb.swapBanks)
          liveQ[g] <= stageNext;
      end
    end
  end

  always_comb begin
    curEntry = Q_IDLE;
    for (int i = 0; i < MAX_SEGS; i++)
      if (segIdx == CNT_W'(i))
        curEntry = liveQ[i];
  end

  seg_select_cmp u_cmp (
    .entry (curEntry),
    .seg   (segData),
    .hit   (segHit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resValid <= 1'b0;
      resData  <= '0;
      resLast  <= 1'b0;
      resPass  <= 1'b0;
      resIdx   <= '0;
    end else begin
      resValid <= strb.evalEn;
      resLast  <= strb.evalEn && strb.lastSeg;
      resPass  <= strb.evalEn && segHit && !strb.overRun;
      if (strb.evalEn) begin
        resData <= segData;
        resIdx  <= segIdx;
      end
    end
  end

endmodule

// File: rtl/seg_select_unit.sv
`timescale 1ns/1ps
module seg_select_unit
  import seg_select_pkg::*;
#(
  parameter int MAX_SEGS = 4,
  localparam int CNT_W  = $clog2(MAX_SEGS + 1),
  localparam int QIDX_W = (MAX_SEGS > 1) ? $clog2(MAX_SEGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              segValid,
  input  logic [63:0]       segData,
  input  logic              segLast,
  input  logic              qWrEn,
  input  logic [QIDX_W-1:0] qWrIdx,
  input  logic [31:0]       qWrAttr,
  input  logic [2:0]        qWrOp,
  input  logic [31:0]       qWrConst,
  input  logic              qCommit,
  output logic              resValid,
  output logic [63:0]       resData,
  output logic              resLast,
  output logic              resPass,
  output logic [CNT_W-1:0]  resIdx
);

  ctrlStrobe_t      strb;
  logic [CNT_W-1:0] segIdx;

  seg_select_ctrl #(.MAX_SEGS(MAX_SEGS)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .segValid (segValid),
    .segLast  (segLast),
    .qCommit  (qCommit),
    .strb     (strb),
    .segIdx   (segIdx)
  );

  seg_select_dp #(.MAX_SEGS(MAX_SEGS)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strb     (strb),
    .segIdx   (segIdx),
    .segData  (segData),
    .qWrEn    (qWrEn),
    .qWrIdx   (qWrIdx),
    .qWrAttr  (qWrAttr),
    .qWrOp    (qWrOp),
    .qWrConst (qWrConst),
    .resValid (resValid),
    .resData  (resData),
    .resLast  (resLast),
    .resPass  (resPass),
    .resIdx   (resIdx)
  );

endmodule

// File: rtl/seg_select_chk.sv
`timescale 1ns/1ps
module seg_select_chk #(
  parameter int MAX_SEGS = 4,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             segValid,
  input logic [63:0]      segData,
  input logic             segLast,
  input logic             resValid,
  input logic [63:0]      resData,
  input logic             resLast,
  input logic             resPass,
  input logic [CNT_W-1:0] resIdx
);

  localparam logic [CNT_W-1:0] SAT = CNT_W'(MAX_SEGS);

  a_r1_result_follows: assert property (@(posedge clk) disable iff (!rst_n)
    segValid |=> resValid);

  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !segValid |=> !resValid);

  a_r2_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    segValid |=> (resData == $past(segData) && resLast == $past(segLast)));

  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && $past(resValid) && $past(resLast)) |-> resIdx == '0);

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && $past(resValid) && !$past(resLast) && $past(resIdx) < SAT)
      |-> resIdx == $past(resIdx) + CNT_W'(1));

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && $past(resValid) && !$past(resLast) && $past(resIdx) == SAT)
      |-> resIdx == SAT);

  a_r9_overrun_fails: assert property (@(posedge clk) disable iff (!rst_n)
    (resValid && resIdx == SAT) |-> !resPass);

endmodule

bind seg_select_unit seg_select_chk #(.MAX_SEGS(MAX_SEGS), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .segValid (segValid),
  .segData  (segData),
  .segLast  (segLast),
  .resValid (resValid),
  .resData  (resData),
  .resLast  (resLast),
  .resPass  (resPass),
  .resIdx   (resIdx)
);

// File: tb/sim_seg_select_unit.sv
`timescale 1ns/1ps
module sim_seg_select_unit;

  localparam int MAXS = 4;
  localparam int CW = $clog2(MAXS + 1);
  localparam int QW = $clog2(MAXS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          segValid, segLast, qWrEn, qCommit;
  logic [63:0]   segData;
  logic [QW-1:0] qWrIdx;
  logic [31:0]   qWrAttr, qWrConst;
  logic [2:0]    qWrOp;
  logic          resValid, resLast, resPass;
  logic [63:0]   resData;
  logic [CW-1:0] resIdx;

  seg_select_unit #(.MAX_SEGS(MAXS)) u0 (
    .clk(clk), .rst_n(rst_n), .segValid(segValid), .segData(segData),
    .segLast(segLast), .qWrEn(qWrEn), .qWrIdx(qWrIdx), .qWrAttr(qWrAttr),
    .qWrOp(qWrOp), .qWrConst(qWrConst), .qCommit(qCommit),
    .resValid(resValid), .resData(resData), .resLast(resLast),
    .resPass(resPass), .resIdx(resIdx)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [31:0] stA [MAXS];
  logic [2:0]  stO [MAXS];
  logic [31:0] stK [MAXS];
  logic [31:0] lvA [MAXS];
  logic [2:0]  lvO [MAXS];
  logic [31:0] lvK [MAXS];
  int mCnt;
  bit mPend;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit ruleHit(logic [2:0] op, logic [31:0] a, logic [31:0] k, logic [63:0] s);
    bit am = (s[63:32] == a);
    case (op)
      3'd0: return am && (s[31:0] == k);
      3'd1: return am && (s[31:0] != k);
      3'd2: return am && (s[31:0] <  k);
      3'd3: return am && (s[31:0] >  k);
      3'd4: return am && (s[31:0] <= k);
      3'd5: return am && (s[31:0] >= k);
      3'd6: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic modelReset();
    for (int i = 0; i < MAXS; i++) begin
      stA[i] = '0; stO[i] = 3'd7; stK[i] = '0;
      lvA[i] = '0; lvO[i] = 3'd7; lvK[i] = '0;
    end
    mCnt = 0;
    mPend = 1'b0;
  endtask

  // one clock: predict from current inputs, advance model, compare at negedge
  task automatic tick(string tag);
    bit eV, eL, eP, eff, bnd;
    logic [63:0] eD;
    int eI;
    eV = segValid; eD = segData; eL = segLast; eI = mCnt;
    eP = segValid && (mCnt < MAXS) && ruleHit(lvO[mCnt], lvA[mCnt], lvK[mCnt], segData);
    if (qWrEn) begin
      stA[qWrIdx] = qWrAttr; stO[qWrIdx] = qWrOp; stK[qWrIdx] = qWrConst;
    end
    eff = mPend || qCommit;
    bnd = (mCnt == 0 && !segValid) || (segValid && segLast);
    if (eff && bnd) begin
      for (int i = 0; i < MAXS; i++) begin
        lvA[i] = stA[i]; lvO[i] = stO[i]; lvK[i] = stK[i];
      end
      mPend = 1'b0;
    end else begin
      mPend = eff;
    end
    if (segValid) mCnt = segLast ? 0 : ((mCnt < MAXS) ? mCnt + 1 : MAXS);
    @(negedge clk);
    chk("R1", "valid", 64'(resValid), 64'(eV));
    if (eV) begin
      chk("R2", "data", resData, eD);
      chk("R2", "last", 64'(resLast), 64'(eL));
      chk((eI == MAXS) ? "R9" : "R3", "idx", 64'(resIdx), 64'(eI));
      chk(tag, "pass", 64'(resPass), 64'(eP));
    end
  endtask

  task automatic clearIn();
    segValid = 0; segLast = 0; segData = '0;
    qWrEn = 0; qWrIdx = '0; qWrAttr = '0; qWrOp = '0; qWrConst = '0; qCommit = 0;
  endtask

  task automatic seg(string tag, int attr, int val, bit last);
    clearIn();
    segValid = 1; segLast = last; segData = {32'(attr), 32'(val)};
    tick(tag);
  endtask

  task automatic wr(string tag, int idx, int attr, int op, int k, bit commit);
    clearIn();
    qWrEn = 1; qWrIdx = QW'(idx); qWrAttr = 32'(attr); qWrOp = 3'(op);
    qWrConst = 32'(k); qCommit = commit;
    tick(tag);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) begin
      clearIn();
      tick(tag);
    end
  endtask

  initial begin
    clearIn();
    rst_n = 0;
    modelReset();
    repeat (3) @(negedge clk);
    // R10: reset state at the ports
    chk("R10", "valid", 64'(resValid), 64'd0);
    chk("R10", "pass", 64'(resPass), 64'd0);
    chk("R10", "last", 64'(resLast), 64'd0);
    rst_n = 1;
    idle("R10", 2);

    // R5: unprogrammed entries never pass, even for code 6 style data
    seg("R5", 0, 0, 1);
    seg("R5", 1, 29, 1);

    // program a two-part query: attr 1 > 25, attr 2 < 180
    wr("R8", 0, 1, 3, 25, 0);
    wr("R8", 1, 2, 2, 180, 1);
    idle("R8", 1);

    // R4/R3: boundaries of both parts
    for (int a = 24; a <= 27; a++)
      for (int h = 178; h <= 181; h++) begin
        seg("R4", 1, a, 0);
        seg("R4", 2, h, 1);
      end
    // R3: swapped order must fail at both positions
    seg("R3", 2, 100, 0);
    seg("R3", 1, 100, 1);
    // R6: attribute mismatch with a value that meets the condition
    seg("R6", 7, 99, 0);
    seg("R6", 2, 5, 1);

    // R4/R5: every operator code at and around the constant
    for (int op = 0; op < 8; op++) begin
      wr("R4", 0, 3, op, 50, 1);
      for (int v = 49; v <= 51; v++) seg((op >= 6) ? "R5" : "R4", 3, v, 1);
      seg((op >= 6) ? "R5" : "R6", 4, 50, 1);
    end

    // R7: staging writes without a commit leave results unchanged
    wr("R8", 0, 5, 6, 0, 1);
    wr("R7", 0, 5, 7, 0, 0);
    seg("R7", 5, 1, 1);
    seg("R7", 9, 9, 1);
    idle("R7", 2);
    seg("R7", 5, 1, 1);

    // R8: commit mid-tuple waits for the last segment
    wr("R8", 1, 6, 6, 0, 1);
    seg("R8", 5, 1, 0);
    clearIn(); qCommit = 1; segValid = 1; segData = {32'd1, 32'd1}; tick("R8");
    seg("R8", 8, 8, 0);
    seg("R8", 8, 8, 1);
    seg("R8", 5, 1, 0);
    seg("R8", 8, 8, 1);
    // R8: staging write on the swap cycle is part of the copy
    wr("R8", 0, 9, 6, 0, 0);
    clearIn(); qCommit = 1; qWrEn = 1; qWrIdx = 1; qWrAttr = 9; qWrOp = 3'd0;
    qWrConst = 77; tick("R8");
    seg("R8", 1, 1, 0);
    seg("R8", 9, 77, 1);

    // R9: over-long tuple with every entry set to code 6
    for (int i = 0; i < MAXS; i++) wr("R9", i, 0, 6, 0, i == MAXS - 1);
    for (int i = 0; i < MAXS + 3; i++) seg("R9", i, i, i == MAXS + 2);
    seg("R9", 0, 0, 1);

    // mixed random traffic
    for (int n = 0; n < 4000; n++) begin
      clearIn();
      segValid = ($urandom_range(9) < 7);
      segLast  = ($urandom_range(9) < 3);
      segData  = {32'($urandom_range(4, 1)), 32'($urandom_range(255))};
      qWrEn    = ($urandom_range(9) < 2);
      qWrIdx   = QW'($urandom_range(MAXS - 1));
      qWrAttr  = 32'($urandom_range(4, 1));
      qWrOp    = 3'($urandom_range(7));
      qWrConst = 32'($urandom_range(255));
      qCommit  = ($urandom_range(19) == 0);
      tick("R3");
    end
    idle("R1", 3);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule